// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Filter

This block receives asynchronous serial frames of eight or nine data bits from a single line. It is paced by a one-cycle enable pulse that arrives at sixteen times the bit rate. A falling edge on the line starts a frame. The oversampling counter is realigned at that edge, and every bit is then taken near its centre. A start bit that has gone high again by its centre is treated as noise, and the frame is dropped.

On a shared bus, many receivers hear every frame. When the address filter is on, a frame only raises the receive flag if it is marked as an address frame and its byte matches this node. A byte can match in two ways. It can equal the own-address value in every position the mask enables. Or it can carry a 1 in every position set in the OR of own-address and mask, which gives the broadcast address. An optional stop-bit check records bad frames in a sticky error flag. In nine-bit frames, this check also moves the moment the receive flag rises from the ninth bit to the stop bit. Both flags are held until the host clears them with a one-cycle pulse.

Top module: `uart_addr_rx`

## Requirements
- R1: A frame starts only when `rx_en` is 1 and, on a `tick16` pulse, the line reads 0 after reading 1 on the previous pulse. Dropping `rx_en` abandons a frame in progress. A frame sent while `rx_en` is 0 leaves all outputs unchanged.
- R2: The start bit is sampled again on the eighth pulse after the edge. If the line is 1 at that point, the frame is dropped without touching any output, and the next real frame is still received.
- R3: Data bits arrive least significant first and are sampled every 16 pulses after the start-bit centre. An accepted frame puts its data byte on `rx_data`.
- R4: On acceptance, `rx_bit9` takes the ninth bit when `nine_bit`=1, and the stop bit when `nine_bit`=0.
- R5: The receive flag rises at the stop-bit sample in eight-bit frames. In nine-bit frames it rises at the ninth-bit sample when `frm_chk_en`=0, and at the stop-bit sample when `frm_chk_en`=1.
- R6: With `frm_chk_en`=1, a stop bit sampled as 0 sets `fe_flag`. Later good frames do not clear it; only `fe_clr` or reset does. With `frm_chk_en`=0 a bad stop bit never sets it.
- R7: With `mp_en`=1 and `nine_bit`=1, a frame is accepted only if its ninth bit is 1 and its byte matches the address filter.
- R8: With `mp_en`=1 and `nine_bit`=0, a frame is accepted only if its stop bit is 1 and its byte matches the address filter.
- R9: Individual match: every position where `addr_mask` is 1 equals `own_addr`. Positions where the mask is 0 are ignored. With both inputs at 00h, every byte matches.
- R10: Broadcast match: the byte has a 1 in every position where `own_addr | addr_mask` is 1.
- R11: `ri_flag` stays at 1 until a `ri_clr` pulse. If a new frame is accepted in the same cycle as a clear, the flag stays set.
- R12: After reset, `ri_flag`, `fe_flag`, `rx_data` and `rx_bit9` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial line, already synchronous to clk, idles high |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en | input | 1 | Receive enable |
| nine_bit | input | 1 | 1 = nine data bits per frame, 0 = eight |
| mp_en | input | 1 | Address filtering enable |
| frm_chk_en | input | 1 | Stop-bit check enable |
| own_addr | input | 8 | Node address |
| addr_mask | input | 8 | Address mask; 0 bits are ignored |
| ri_clr | input | 1 | Clear pulse for ri_flag |
| fe_clr | input | 1 | Clear pulse for fe_flag |
| rx_data | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit or stop bit of the last accepted frame |
| fe_flag | output | 1 | Sticky framing error |
| ri_flag | output | 1 | Receive flag |

## Verification
The bench reads `ri_flag` early in the stop bit, to catch a design that raises the flag at the wrong sample point: too late for nine-bit frames without the check, or too early with it. A short low glitch is sent to catch a receiver that locks onto noise and then takes the next real frame out of step. Address frames are sent to three kinds of node setting: a masked individual match, a broadcast-only pattern, and the all-zero reset setting. These would expose a filter that compares bits the mask ignores, or one that forms the broadcast pattern wrongly. A bad stop bit followed by a good frame shows whether the error flag is really sticky, and a bad stop bit in eight-bit address mode shows whether the stop bit acts as the address mark.

// File: rtl/uart_addr_rx_pkg.sv
// Shared types for the multidrop serial receiver.
package uart_addr_rx_pkg;
    // Receiver sequencing state
    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_state_t;
endpackage

// File: rtl/uart_rx_sampler.sv
// Start detection, mid-bit sampling and the input shift register.
// Assumes: rxd is already synchronous to clk; OVS is a power of two, so the
// oversampling counter wraps on its own; mode inputs stay fixed during a frame.
// Gives one-cycle event pulses at the ninth-bit and stop-bit samples, and the
// frame's data byte and mark bit as seen at that moment.
module uart_rx_sampler
    import uart_addr_rx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              tick,
    input  logic              rx_en,
    input  logic              nine_bit,
    output logic              ev_ninth,
    output logic              ev_stop,
    output logic              ev_bit,
    output logic [DATA_W-1:0] frame_data,
    output logic              frame_mark
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W + 3);
    localparam int SR_W  = DATA_W + 1;
    localparam logic [CNT_W-1:0] MID_C      = CNT_W'(OVS / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_FIRST  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_LASTD  = IDX_W'(DATA_W);
    localparam logic [IDX_W-1:0] IDX_NINTH  = IDX_W'(DATA_W + 1);
    localparam logic [IDX_W-1:0] IDX_STOP9  = IDX_W'(DATA_W + 2);

    rx_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [SR_W-1:0]  sr;
    logic             line_q;
    logic [IDX_W-1:0] last_idx;
    logic             sample_now;
    logic             shift_en;

    // Index of the stop bit for the selected frame length
    assign last_idx   = nine_bit ? IDX_STOP9 : IDX_NINTH;
    // A mid-bit sample is taken on this cycle
    assign sample_now = (state == RX_BUSY) && tick && rx_en && (cnt == MID_C);
    // Data bits and the ninth bit enter the shift register; the stop bit does not
    assign shift_en   = ((idx >= IDX_FIRST) && (idx <= IDX_LASTD)) ||
                        (nine_bit && (idx == IDX_NINTH));

    assign ev_ninth   = sample_now && nine_bit && (idx == IDX_NINTH);
    assign ev_stop    = sample_now && (idx == last_idx);
    assign ev_bit     = rxd;

    // Byte and mark as they stand at the current event
    always_comb begin
        if (nine_bit && (idx == IDX_STOP9)) begin
            frame_data = sr[DATA_W-1:0];
            frame_mark = sr[SR_W-1];
        end else begin
            frame_data = sr[SR_W-1:1];
            frame_mark = rxd;
        end
    end

    // Sequencing: edge detect, counter realign, sampling and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            idx    <= '0;
            sr     <= '1;
            line_q <= 1'b1;
        end else begin
            if (tick) line_q <= rxd;
            case (state)
                RX_IDLE: begin
                    if (tick && rx_en && line_q && !rxd) begin
                        state <= RX_BUSY;
                        cnt   <= '0;
                        idx   <= '0;
                        sr    <= '1;
                    end
                end
                default: begin
                    if (!rx_en) begin
                        state <= RX_IDLE;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == MID_C) begin
                            if ((idx == '0) && rxd) state <= RX_IDLE;
                            else if (idx == last_idx) state <= RX_IDLE;
                            else idx <= idx + 1'b1;
                            if (shift_en) sr <= {rxd, sr[SR_W-1:1]};
                        end
                    end
                end
            endcase
        end
    end

    // R1
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> state == RX_IDLE);
    // R5
    stop_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> state == RX_IDLE);
    // R2
    no_event_in_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ninth || ev_stop) |-> idx != '0);
endmodule

// File: rtl/uart_addr_match.sv
// Address filter: a masked individual compare and a broadcast compare.
// Purely combinational; the byte under test comes from the sampler.
module uart_addr_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] own,
    input  logic [W-1:0] mask,
    output logic         hit
);
    logic [W-1:0] bcast_pat;
    logic         given_hit;
    logic         bcast_hit;

    // Enabled positions equal the own address
    assign given_hit = (((addr ^ own) & mask) == '0);
    // Broadcast pattern needs a 1 wherever own|mask is 1
    assign bcast_pat = own | mask;
    assign bcast_hit = (((~addr) & bcast_pat) == '0);
    assign hit       = given_hit || bcast_hit;
endmodule

// File: rtl/uart_rx_flags.sv
// Acceptance rules, the receive flag, the sticky framing error and the
// output registers. Assumes the sampler events are single-cycle pulses.
module uart_rx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ninth,
    input  logic              ev_stop,
    input  logic              ev_bit,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_mark,
    input  logic              nine_bit,
    input  logic              mp_en,
    input  logic              chk_en,
    input  logic              addr_hit,
    input  logic              ri_clr,
    input  logic              fe_clr,
    output logic              ri_q,
    output logic              fe_q,
    output logic [DATA_W-1:0] data_q,
    output logic              bit9_q
);
    logic commit_pt;
    logic accept;
    logic fe_set;

    // Decision point: ninth bit for unchecked nine-bit frames, else stop bit
    assign commit_pt = (nine_bit && !chk_en) ? ev_ninth : ev_stop;
    // Filter: mark bit set and address hit when filtering is on
    assign accept    = commit_pt && (!mp_en || (frame_mark && addr_hit));
    // Stop bit read as 0 while checking
    assign fe_set    = ev_stop && chk_en && !ev_bit;

    // Receive flag and captured frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ri_q   <= 1'b0;
            data_q <= '0;
            bit9_q <= 1'b0;
        end else if (accept) begin
            ri_q   <= 1'b1;
            data_q <= frame_data;
            bit9_q <= frame_mark;
        end else if (ri_clr) begin
            ri_q   <= 1'b0;
        end
    end

    // Sticky framing error
    always_ff @(posedge clk) begin
        if (!rst_n)      fe_q <= 1'b0;
        else if (fe_set) fe_q <= 1'b1;
        else if (fe_clr) fe_q <= 1'b0;
    end

    // R6
    fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fe_q && !fe_clr |=> fe_q);
    // R6
    fe_needs_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en && !fe_q |=> !fe_q);
    // R11
    ri_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ri_q && !ri_clr |=> ri_q);
    // R5
    ri_rise_at_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ri_q) |-> $past(ev_ninth || ev_stop));
endmodule

// File: rtl/uart_addr_rx.sv
// Top of the multidrop serial receiver: sampler, address filter, flag logic.
// Assumes rxd is synchronous to clk and tick16 is a single-cycle pulse.
module uart_addr_rx #(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              tick16,
    input  logic              rx_en,
    input  logic              nine_bit,
    input  logic              mp_en,
    input  logic              frm_chk_en,
    input  logic [DATA_W-1:0] own_addr,
    input  logic [DATA_W-1:0] addr_mask,
    input  logic              ri_clr,
    input  logic              fe_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              fe_flag,
    output logic              ri_flag
);
    logic              ev_ninth;
    logic              ev_stop;
    logic              ev_bit;
    logic [DATA_W-1:0] frame_data;
    logic              frame_mark;
    logic              addr_hit;

    uart_rx_sampler #(.OVS(OVS), .DATA_W(DATA_W)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd        (rxd),
        .tick       (tick16),
        .rx_en      (rx_en),
        .nine_bit   (nine_bit),
        .ev_ninth   (ev_ninth),
        .ev_stop    (ev_stop),
        .ev_bit     (ev_bit),
        .frame_data (frame_data),
        .frame_mark (frame_mark)
    );

    uart_addr_match #(.W(DATA_W)) u_match (
        .addr (frame_data),
        .own  (own_addr),
        .mask (addr_mask),
        .hit  (addr_hit)
    );

    uart_rx_flags #(.DATA_W(DATA_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_ninth   (ev_ninth),
        .ev_stop    (ev_stop),
        .ev_bit     (ev_bit),
        .frame_data (frame_data),
        .frame_mark (frame_mark),
        .nine_bit   (nine_bit),
        .mp_en      (mp_en),
        .chk_en     (frm_chk_en),
        .addr_hit   (addr_hit),
        .ri_clr     (ri_clr),
        .fe_clr     (fe_clr),
        .ri_q       (ri_flag),
        .fe_q       (fe_flag),
        .data_q     (rx_data),
        .bit9_q     (rx_bit9)
    );
endmodule

// File: tb/uart_addr_rx_bench.sv
// Directed bench: one task per scenario; each task checks its own results.
module uart_addr_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       tick16 = 1'b0;
    logic       rx_en = 1'b1;
    logic       nine_bit = 1'b0;
    logic       mp_en = 1'b0;
    logic       frm_chk_en = 1'b0;
    logic [7:0] own_addr = 8'h00;
    logic [7:0] addr_mask = 8'h00;
    logic       ri_clr = 1'b0;
    logic       fe_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       fe_flag;
    logic       ri_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    localparam int BITCLK = 64;   // 16 ticks of 4 clocks

    uart_addr_rx u_uart_addr_rx (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16), .rx_en(rx_en),
        .nine_bit(nine_bit), .mp_en(mp_en), .frm_chk_en(frm_chk_en),
        .own_addr(own_addr), .addr_mask(addr_mask), .ri_clr(ri_clr),
        .fe_clr(fe_clr), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .fe_flag(fe_flag), .ri_flag(ri_flag)
    );

    always #2.5 clk = ~clk;

    // Tick pulse every fourth clock
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    // Send one frame; early = ri_flag eight clocks into the stop bit
    task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop_v,
                              output logic early);
        hold(1'b0, BITCLK);
        for (int i = 0; i < 8; i++) hold(d[i], BITCLK);
        if (nine_bit) hold(b9, BITCLK);
        hold(stop_v, 8);
        early = ri_flag;
        hold(stop_v, BITCLK - 8);
        hold(1'b1, BITCLK);
    endtask

    task automatic clear_ri;
        @(negedge clk); ri_clr = 1'b1;
        @(negedge clk); ri_clr = 1'b0;
    endtask

    task automatic t_reset;
        // R12
        chk("R12", "ri after reset", ri_flag, 0);
        chk("R12", "fe after reset", fe_flag, 0);
        chk("R12", "data after reset", rx_data, 0);
        chk("R12", "bit9 after reset", rx_bit9, 0);
    endtask

    task automatic t_plain8;
        logic e;
        nine_bit = 0; mp_en = 0; frm_chk_en = 0;
        send_frame(8'hA5, 1'b0, 1'b1, e);
        chk("R5", "8-bit flag not before stop sample", e, 0);
        chk("R3", "8-bit data", rx_data, 8'hA5);
        chk("R4", "8-bit stores stop bit", rx_bit9, 1);
        chk("R5", "8-bit flag after stop", ri_flag, 1);
        // R11 flag holds with no clear
        repeat (200) @(negedge clk);
        chk("R11", "flag held", ri_flag, 1);
        clear_ri;
        chk("R11", "flag cleared", ri_flag, 0);
    endtask

    task automatic t_plain9;
        logic e;
        nine_bit = 1; mp_en = 0; frm_chk_en = 0;
        send_frame(8'h3C, 1'b0, 1'b1, e);
        chk("R5", "9-bit unchecked flag at ninth bit", e, 1);
        chk("R3", "9-bit data", rx_data, 8'h3C);
        chk("R4", "9-bit stores ninth bit", rx_bit9, 0);
        clear_ri;
        frm_chk_en = 1;
        send_frame(8'hC3, 1'b1, 1'b1, e);
        chk("R5", "9-bit checked flag waits for stop", e, 0);
        chk("R5", "9-bit checked flag after stop", ri_flag, 1);
        chk("R4", "ninth bit one", rx_bit9, 1);
        chk("R3", "9-bit data second", rx_data, 8'hC3);
        clear_ri;
        frm_chk_en = 0;
    endtask

    task automatic t_framing;
        logic e;
        nine_bit = 0; mp_en = 0; frm_chk_en = 0;
        send_frame(8'h11, 1'b0, 1'b0, e);
        chk("R6", "no error when unchecked", fe_flag, 0);
        clear_ri;
        frm_chk_en = 1;
        send_frame(8'h22, 1'b0, 1'b0, e);
        chk("R6", "error on bad stop", fe_flag, 1);
        clear_ri;
        send_frame(8'h33, 1'b0, 1'b1, e);
        chk("R6", "error sticky after good frame", fe_flag, 1);
        chk("R3", "good frame still received", rx_data, 8'h33);
        @(negedge clk); fe_clr = 1'b1;
        @(negedge clk); fe_clr = 1'b0;
        chk("R6", "error cleared", fe_flag, 0);
        clear_ri;
        frm_chk_en = 0;
    endtask

    task automatic t_glitch;
        logic e;
        nine_bit = 0; mp_en = 0;
        hold(1'b0, 16);
        hold(1'b1, 12 * BITCLK);
        chk("R2", "glitch gives no flag", ri_flag, 0);
        chk("R2", "glitch leaves data", rx_data, 8'h33);
        send_frame(8'h5A, 1'b0, 1'b1, e);
        chk("R2", "frame after glitch", rx_data, 8'h5A);
        clear_ri;
    endtask

    task automatic t_disabled;
        logic e;
        rx_en = 0;
        send_frame(8'hEE, 1'b0, 1'b1, e);
        chk("R1", "disabled: no flag", ri_flag, 0);
        chk("R1", "disabled: data unchanged", rx_data, 8'h5A);
        rx_en = 1;
        hold(1'b1, BITCLK);
    endtask

    task automatic t_mp9;
        logic e;
        nine_bit = 1; mp_en = 1; frm_chk_en = 0;
        own_addr = 8'h56; addr_mask = 8'hFC;
        send_frame(8'h57, 1'b1, 1'b1, e);
        chk("R9", "masked individual match", ri_flag, 1);
        chk("R7", "address byte stored", rx_data, 8'h57);
        clear_ri;
        send_frame(8'h5A, 1'b1, 1'b1, e);
        chk("R9", "mismatch rejected", ri_flag, 0);
        send_frame(8'h56, 1'b0, 1'b1, e);
        chk("R7", "data frame (ninth 0) rejected", ri_flag, 0);
        send_frame(8'hFE, 1'b1, 1'b1, e);
        chk("R10", "broadcast accepted", ri_flag, 1);
        clear_ri;
        own_addr = 8'hF1; addr_mask = 8'hFA;   // individual 1111_0x0x, broadcast 1111_1x11
        send_frame(8'hFB, 1'b1, 1'b1, e);
        chk("R10", "broadcast FB accepted", ri_flag, 1);
        clear_ri;
        send_frame(8'hF3, 1'b1, 1'b1, e);
        chk("R9", "F3 fails both filters", ri_flag, 0);
        own_addr = 8'h00; addr_mask = 8'h00;
        send_frame(8'h9C, 1'b1, 1'b1, e);
        chk("R9", "zero filter matches all", ri_flag, 1);
        clear_ri;
    endtask

    task automatic t_mp8;
        logic e;
        nine_bit = 0; mp_en = 1; frm_chk_en = 0;
        own_addr = 8'h56; addr_mask = 8'hFF;
        send_frame(8'h56, 1'b0, 1'b1, e);
        chk("R8", "8-bit address with good stop", ri_flag, 1);
        clear_ri;
        send_frame(8'h56, 1'b0, 1'b0, e);
        chk("R8", "8-bit address with bad stop", ri_flag, 0);
        send_frame(8'h57, 1'b0, 1'b1, e);
        chk("R8", "8-bit wrong address", ri_flag, 0);
        mp_en = 0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset;
        t_plain8;
        t_plain9;
        t_framing;
        t_glitch;
        t_disabled;
        t_mp9;
        t_mp8;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule